// File: doc/BRIEF.md
# Four-Way Set-Associative TLB with Test-Register Access

This block is a translation lookaside buffer of eight sets by four ways. Each entry maps a linear page number to a physical page number and also stores a valid flag and three attribute bits: dirty, user and writable. Replacement uses a three-bit tree pseudo-LRU kept for each set. The block is reached only through two 32-bit registers: a command word and a data word. Writing the command word starts one operation. That operation either searches the buffer or installs an entry.

In the command word, bits 31:12 carry the linear page number. Bit 11 is the valid flag, and bit 0 selects the operation. Three two-bit attribute fields sit in bits 10:9 (dirty), 8:7 (user) and 6:5 (writable). Each field holds a bit in its upper position and that bit's complement in its lower position. On a search these fields act as match masks. On an install they act as set/clear actions. The data word holds four fields: the physical page number in 31:12, a snapshot of the set's replacement state in 9:7, a hit/select flag in bit 4 and a way number in 3:2. The set index is linear page bits 2:0 (address bits 14:12), and the remaining 17 bits form the stored tag.

Every operation completes at the first clock edge after the command write. A one-cycle `done` pulse follows at that edge.

Top module: `tlb_testport`

## Requirements
- R1: A data-word write stores only bits 31:12, 9:7, 4 and 3:2. All other data-word bits always read as zero.
- R2: A search (command bit 0 = 1) hits when exactly one valid entry of the set matches. On a hit, the data word returns the entry's physical page in 31:12, 1 in bit 4, the way in 3:2, and in 9:7 the set's replacement bits as they were before the search.
- R3: On a search, attribute field code 00 never matches, 01 matches a stored 0, 10 matches a stored 1, and 11 matches either value.
- R4: A search that matches no entry, or more than one entry, leaves the whole data word at zero.
- R5: An install (command bit 0 = 0) with data bit 4 = 1 writes into the way named by data bits 3:2.
- R6: An install with data bit 4 = 0 writes into the pseudo-LRU victim. Replacement bit 0 = 0 selects ways {0,1}, and then bit 1 picks way 1 over way 0. Replacement bit 0 = 1 selects ways {2,3}, and then bit 2 picks way 3 over way 2. From reset, four such installs in one set fill ways 0, 2, 1, 3 in that order.
- R7: On an install, attribute code 01 clears the stored bit and 10 sets it. Codes 00 and 11 leave the stored bit unchanged.
- R8: An install stores the tag and the data-word physical page. Its command bit 11 becomes the entry's valid flag, so a 0 invalidates the entry.
- R9: `done` is high for exactly the one cycle after a command write. The data word holds the result of the operation in that same cycle, and an install leaves the data word unchanged.
- R10: A synchronous reset clears every valid flag, every replacement state and the data word.
- R11: A hit or an install moves the tree bits on the accessed path so that they point away from the accessed way. A miss leaves the replacement state unchanged.
- R12: Entries in different sets never match each other, and entries in the same set with different tags never match each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Command-word write strobe; starts an operation |
| ctrl_wdata | input | 32 | Command word |
| data_we | input | 1 | Data-word write strobe (ignored when a search completes in the same cycle) |
| data_wdata | input | 32 | Data word to store |
| data_q | output | 32 | Data word as read back |
| done | output | 1 | One-cycle pulse marking completion of an operation |

## Verification
A corrupted tree state never shows up by itself. It surfaces either in the 9:7 snapshot of the next hit in that set, or as the wrong way in bits 3:2 once an install-by-LRU entry is searched for. The fill-order and hit-after-miss sequences are built to expose such a fault within two operations. A stale valid flag or attribute shows up in the next search of that set as a wrongly single hit, or as a double match that zeroes the data word. That search follows one cycle after the command write.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int WAYS   = 4;
  localparam int WAY_W  = 2;
  localparam int PAGE_W = 20;
  localparam int LRU_W  = 3;

  typedef logic [1:0] pair_t;

  // Search: upper bit admits a stored 1, lower bit admits a stored 0
  function automatic logic pair_match(input pair_t p, input logic s);
    return (p[1] & s) | (p[0] & ~s);
  endfunction

  // Install: 10 sets, 01 clears, other codes keep
  function automatic logic pair_apply(input pair_t p, input logic old);
    case (p)
      2'b10:   return 1'b1;
      2'b01:   return 1'b0;
      default: return old;
    endcase
  endfunction

  function automatic logic [WAY_W-1:0] plru_victim(input logic [LRU_W-1:0] t);
    if (!t[0]) return t[1] ? 2'd1 : 2'd0;
    else       return t[2] ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [LRU_W-1:0] plru_touch(input logic [LRU_W-1:0] t,
                                                  input logic [WAY_W-1:0] w);
    logic [LRU_W-1:0] n;
    n = t;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = (w == 2'd0);
    end else begin
      n[0] = 1'b0;
      n[2] = (w == 2'd2);
    end
    return n;
  endfunction
endpackage

// File: rtl/tlb_way.sv
module tlb_way
  import tlb_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int IDX_W = $clog2(SETS),
  parameter int TAG_W = PAGE_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] tag,
  input  pair_t            d_pair,
  input  pair_t            u_pair,
  input  pair_t            r_pair,
  input  logic             we,
  input  logic             wr_valid,
  input  logic [PAGE_W-1:0] wr_ppn,
  output logic             match,
  output logic [PAGE_W-1:0] rd_ppn
);
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [PAGE_W-1:0] ppn_mem  [SETS];
  logic [2:0]        attr_mem [SETS];   // {dirty, user, writable}
  logic [SETS-1:0]   valid_q;

  logic [2:0] attr_rd;
  assign attr_rd = attr_mem[set_idx];
  assign rd_ppn  = ppn_mem[set_idx];

  // Payload without reset so it can map onto plain RAM
  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[set_idx]  <= tag;
      ppn_mem[set_idx]  <= wr_ppn;
      attr_mem[set_idx] <= {pair_apply(d_pair, attr_rd[2]),
                            pair_apply(u_pair, attr_rd[1]),
                            pair_apply(r_pair, attr_rd[0])};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     valid_q <= '0;
    else if (we) valid_q[set_idx] <= wr_valid;
  end

  always_comb begin
    match = valid_q[set_idx] && (tag_mem[set_idx] == tag) &&
            pair_match(d_pair, attr_rd[2]) &&
            pair_match(u_pair, attr_rd[1]) &&
            pair_match(r_pair, attr_rd[0]);
  end

  // R8: the valid flag follows the install command
  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    we |=> valid_q[$past(set_idx)] == $past(wr_valid));
endmodule

// File: rtl/tlb_plru.sv
module tlb_plru
  import tlb_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             upd_en,
  input  logic [WAY_W-1:0] upd_way,
  output logic [LRU_W-1:0] tree,
  output logic [WAY_W-1:0] victim
);
  logic [LRU_W-1:0] tree_q [SETS];

  assign tree   = tree_q[set_idx];
  assign victim = plru_victim(tree);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (upd_en) begin
      tree_q[set_idx] <= plru_touch(tree, upd_way);
    end
  end

  // Checker state: last touched set and way
  logic             chk_v;
  logic [IDX_W-1:0] chk_set;
  logic [WAY_W-1:0] chk_way;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_v   <= 1'b0;
      chk_set <= '0;
      chk_way <= '0;
    end else begin
      chk_v   <= upd_en;
      chk_set <= set_idx;
      chk_way <= upd_way;
    end
  end

  // R11: after a touch the tree never points at the way just used
  assert_points_away_R11: assert property (@(posedge clk) disable iff (rst)
    chk_v |-> plru_victim(tree_q[chk_set]) != chk_way);
endmodule

// File: rtl/tlb_testport.sv
module tlb_testport
  import tlb_pkg::*;
#(
  parameter int SETS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrl_we,
  input  logic [31:0] ctrl_wdata,
  input  logic        data_we,
  input  logic [31:0] data_wdata,
  output logic [31:0] data_q,
  output logic        done
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = PAGE_W - IDX_W;
  localparam logic [31:0] DATA_MASK = 32'hFFFF_F39C;

  logic [PAGE_W-1:0] lpage;
  logic [IDX_W-1:0]  set_idx;
  logic [TAG_W-1:0]  tag;
  pair_t             d_pair, u_pair, r_pair;
  logic              is_lookup, lookup_go, write_go;

  assign lpage     = ctrl_wdata[31:12];
  assign set_idx   = lpage[IDX_W-1:0];
  assign tag       = lpage[PAGE_W-1:IDX_W];
  assign d_pair    = ctrl_wdata[10:9];
  assign u_pair    = ctrl_wdata[8:7];
  assign r_pair    = ctrl_wdata[6:5];
  assign is_lookup = ctrl_wdata[0];
  assign lookup_go = ctrl_we &  is_lookup;
  assign write_go  = ctrl_we & ~is_lookup;

  logic [LRU_W-1:0] tree;
  logic [WAY_W-1:0] victim, wr_way, hit_way, upd_way;
  logic [WAYS-1:0]  match_v, way_we;
  logic [PAGE_W-1:0] rd_ppn [WAYS];
  logic             single_hit, upd_en;

  assign wr_way = data_q[4] ? data_q[3:2] : victim;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_we[w] = write_go && (wr_way == WAY_W'(w));
    tlb_way #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_way (
      .clk     (clk),
      .rst     (rst),
      .set_idx (set_idx),
      .tag     (tag),
      .d_pair  (d_pair),
      .u_pair  (u_pair),
      .r_pair  (r_pair),
      .we      (way_we[w]),
      .wr_valid(ctrl_wdata[11]),
      .wr_ppn  (data_q[31:12]),
      .match   (match_v[w]),
      .rd_ppn  (rd_ppn[w])
    );
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (match_v[w]) hit_way = WAY_W'(w);
  end
  assign single_hit = (match_v != '0) && ((match_v & (match_v - 1'b1)) == '0);

  assign upd_en  = (lookup_go && single_hit) || write_go;
  assign upd_way = lookup_go ? hit_way : wr_way;

  tlb_plru #(.SETS(SETS), .IDX_W(IDX_W)) u_plru (
    .clk    (clk),
    .rst    (rst),
    .set_idx(set_idx),
    .upd_en (upd_en),
    .upd_way(upd_way),
    .tree   (tree),
    .victim (victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= ctrl_we;
      if (lookup_go)
        data_q <= single_hit ? {rd_ppn[hit_way], 2'b00, tree, 2'b00, 1'b1, hit_way, 2'b00}
                             : 32'h0;
      else if (data_we)
        data_q <= data_wdata & DATA_MASK;
    end
  end

  // Checker state: the previous cycle completed a search
  logic lkp_q;
  always_ff @(posedge clk) begin
    if (rst) lkp_q <= 1'b0;
    else     lkp_q <= lookup_go;
  end

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
    data_q[11:10] == 2'b00 && data_q[6:5] == 2'b00 && data_q[1:0] == 2'b00);

  assert_miss_clears_R4: assert property (@(posedge clk) disable iff (rst)
    lkp_q && !data_q[4] |-> data_q == 32'h0);

  assert_multi_no_hit_R4: assert property (@(posedge clk) disable iff (rst)
    lookup_go && ($countones(match_v) > 1) |=> !data_q[4]);

  assert_hit_reports_R2: assert property (@(posedge clk) disable iff (rst)
    lookup_go && ($countones(match_v) == 1) |=> data_q[4] && done);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |=> done);

  assert_install_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    write_go && !data_we |=> $stable(data_q));
endmodule

// File: tb/tb_tlb_testport.sv
`timescale 1ns/100ps
module tb_tlb_testport;
  logic        clk = 1'b0;
  logic        rst;
  logic        ctrl_we, data_we;
  logic [31:0] ctrl_wdata, data_wdata;
  logic [31:0] data_q;
  logic        done;

  always #2.5 clk = ~clk;

  tlb_testport dut (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .data_q(data_q), .done(done)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // Command word: page, valid, dirty pair, user pair, writable pair, op
  function automatic logic [31:0] mkc(input logic [19:0] la, input logic v,
      input logic [1:0] d, input logic [1:0] u, input logic [1:0] r, input logic c);
    return {la, v, d, u, r, 4'b0000, c};
  endfunction

  // Data word: page, tree snapshot, hit/select flag, way
  function automatic logic [31:0] mkd(input logic [19:0] pa, input logic [2:0] lru,
      input logic pl, input logic [1:0] rep);
    return {pa, 2'b00, lru, 2'b00, pl, rep, 2'b00};
  endfunction

  typedef struct packed {
    logic        dw;
    logic [31:0] dval;
    logic [31:0] cval;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    // R6 install by LRU into set 0, way 0
    '{1'b1, mkd(20'hAAAAA,3'd0,1'b0,2'd0), mkc(20'h00010,1'b1,2'b10,2'b01,2'b10,1'b0), mkd(20'hAAAAA,3'd0,1'b0,2'd0), 8'd6},
    // R2 search hit way 0, tree before = 011
    '{1'b0, 32'h0, mkc(20'h00010,1'b0,2'b11,2'b11,2'b11,1'b1), mkd(20'hAAAAA,3'b011,1'b1,2'd0), 8'd2},
    // R6 LRU victim is way 2; data tree field ignored
    '{1'b1, mkd(20'hBBBBB,3'b111,1'b0,2'd0), mkc(20'h00020,1'b1,2'b01,2'b10,2'b01,1'b0), mkd(20'hBBBBB,3'b111,1'b0,2'd0), 8'd6},
    // R3 masks 01/10/11 match stored 0/1/any
    '{1'b0, 32'h0, mkc(20'h00020,1'b0,2'b01,2'b10,2'b11,1'b1), mkd(20'hBBBBB,3'b110,1'b1,2'd2), 8'd3},
    // R3 mask 10 against stored 0 misses
    '{1'b0, 32'h0, mkc(20'h00020,1'b0,2'b10,2'b11,2'b11,1'b1), 32'h0, 8'd3},
    // R3 mask 00 never matches
    '{1'b0, 32'h0, mkc(20'h00020,1'b0,2'b11,2'b00,2'b11,1'b1), 32'h0, 8'd3},
    // R2 exact masks hit way 0, tree before = 110
    '{1'b0, 32'h0, mkc(20'h00010,1'b0,2'b10,2'b01,2'b10,1'b1), mkd(20'hAAAAA,3'b110,1'b1,2'd0), 8'd2},
    // R5 forced install of same tag into way 3
    '{1'b1, mkd(20'hCCCCC,3'd0,1'b1,2'd3), mkc(20'h00010,1'b1,2'b10,2'b01,2'b10,1'b0), mkd(20'hCCCCC,3'd0,1'b1,2'd3), 8'd5},
    // R4 two matches give all zero
    '{1'b0, 32'h0, mkc(20'h00010,1'b0,2'b11,2'b11,2'b11,1'b1), 32'h0, 8'd4},
    // R8 invalidate way 0
    '{1'b1, mkd(20'h00000,3'd0,1'b1,2'd0), mkc(20'h00010,1'b0,2'b11,2'b11,2'b11,1'b0), mkd(20'h00000,3'd0,1'b1,2'd0), 8'd8},
    // R8 only way 3 left; tree before = 011
    '{1'b0, 32'h0, mkc(20'h00010,1'b0,2'b11,2'b11,2'b11,1'b1), mkd(20'hCCCCC,3'b011,1'b1,2'd3), 8'd8},
    // R7 codes 00/11 keep attributes
    '{1'b1, mkd(20'hDDDDD,3'd0,1'b1,2'd3), mkc(20'h00010,1'b1,2'b00,2'b11,2'b00,1'b0), mkd(20'hDDDDD,3'd0,1'b1,2'd3), 8'd7},
    // R7 kept attributes D=1 U=0 W=1 still match
    '{1'b0, 32'h0, mkc(20'h00010,1'b0,2'b10,2'b01,2'b10,1'b1), mkd(20'hDDDDD,3'b010,1'b1,2'd3), 8'd7},
    // R7 code 01 clears dirty
    '{1'b1, mkd(20'hDDDDD,3'd0,1'b1,2'd3), mkc(20'h00010,1'b1,2'b01,2'b11,2'b11,1'b0), mkd(20'hDDDDD,3'd0,1'b1,2'd3), 8'd7},
    // R7 dirty now 0, mask 10 misses
    '{1'b0, 32'h0, mkc(20'h00010,1'b0,2'b10,2'b11,2'b11,1'b1), 32'h0, 8'd7},
    // R7 mask 01 hits
    '{1'b0, 32'h0, mkc(20'h00010,1'b0,2'b01,2'b11,2'b11,1'b1), mkd(20'hDDDDD,3'b010,1'b1,2'd3), 8'd7},
    // R12 same tag in set 1 misses
    '{1'b0, 32'h0, mkc(20'h00011,1'b0,2'b11,2'b11,2'b11,1'b1), 32'h0, 8'd12},
    // R12 install in set 1 uses its own tree: way 0
    '{1'b1, mkd(20'hEEEEE,3'd0,1'b0,2'd0), mkc(20'h00011,1'b1,2'b10,2'b10,2'b10,1'b0), mkd(20'hEEEEE,3'd0,1'b0,2'd0), 8'd12},
    // R12 set 1 hit
    '{1'b0, 32'h0, mkc(20'h00011,1'b0,2'b11,2'b11,2'b11,1'b1), mkd(20'hEEEEE,3'b011,1'b1,2'd0), 8'd12},
    // R12 set 0 entry unaffected
    '{1'b0, 32'h0, mkc(20'h00010,1'b0,2'b11,2'b11,2'b11,1'b1), mkd(20'hDDDDD,3'b010,1'b1,2'd3), 8'd12},
    // R12 different tag, same set, misses
    '{1'b0, 32'h0, mkc(20'h00018,1'b0,2'b11,2'b11,2'b11,1'b1), 32'h0, 8'd12}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic put_data(input logic [31:0] v);
    @(negedge clk); data_we = 1'b1; data_wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  // Issues a command; returns at the negedge after the completing edge
  task automatic put_ctrl(input logic [31:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  initial begin
    rst = 1'b1; ctrl_we = 1'b0; data_we = 1'b0; ctrl_wdata = '0; data_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 data after reset", data_q, 32'h0);
    check("R9 done idle after reset", {31'b0, done}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].dw) put_data(VEC[i].dval);
      put_ctrl(VEC[i].cval);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), data_q, VEC[i].exp);
    end

    // R1 mask of data-word writes
    put_data(32'hFFFF_FFFF);
    check("R1 masked data write", data_q, 32'hFFFF_F39C);

    // R9 done pulse width and install leaves data word as is
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = mkc(20'h00077,1'b0,2'b11,2'b11,2'b11,1'b0);
    check("R9 done low during write cycle", {31'b0, done}, 32'h0);
    @(negedge clk); ctrl_we = 1'b0;
    check("R9 done high next cycle", {31'b0, done}, 32'h1);
    check("R9 install keeps data word", data_q, 32'hFFFF_F39C);
    @(negedge clk);
    check("R9 done drops", {31'b0, done}, 32'h0);

    // R10 reset empties the buffer
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R10 data cleared", data_q, 32'h0);
    put_ctrl(mkc(20'h00011,1'b0,2'b11,2'b11,2'b11,1'b1));
    check("R10 entry gone after reset", data_q, 32'h0);

    // R6 fill order 0,2,1,3 in set 5 from cleared tree
    for (int k = 0; k < 4; k++) begin
      put_data(mkd(20'h10001 + 20'(k), 3'd0, 1'b0, 2'd0));
      put_ctrl(mkc(20'h0000D + 20'(k*8), 1'b1, 2'b10, 2'b10, 2'b10, 1'b0));
    end
    // R11 miss leaves tree at 000
    put_ctrl(mkc(20'h0002D,1'b0,2'b11,2'b11,2'b11,1'b1));
    check("R11 miss in filled set", data_q, 32'h0);
    put_ctrl(mkc(20'h0000D,1'b0,2'b11,2'b11,2'b11,1'b1));
    check("R11 tree unchanged by miss; R6 first fill way0", data_q, mkd(20'h10001,3'b000,1'b1,2'd0));
    put_ctrl(mkc(20'h0000D,1'b0,2'b11,2'b11,2'b11,1'b1));
    check("R11 hit moved tree", data_q, mkd(20'h10001,3'b011,1'b1,2'd0));
    put_ctrl(mkc(20'h00015,1'b0,2'b11,2'b11,2'b11,1'b1));
    check("R6 second fill way2", data_q, mkd(20'h10002,3'b011,1'b1,2'd2));
    put_ctrl(mkc(20'h0001D,1'b0,2'b11,2'b11,2'b11,1'b1));
    check("R6 third fill way1", data_q, mkd(20'h10003,3'b110,1'b1,2'd1));
    put_ctrl(mkc(20'h00025,1'b0,2'b11,2'b11,2'b11,1'b1));
    check("R6 fourth fill way3", data_q, mkd(20'h10004,3'b101,1'b1,2'd3));

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule